// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank with Reload and Event Interrupts

This block keeps two copies of a small set of configuration words. Software writes only the staging copy. The working copy, which drives the rest of the display pipeline, changes only when a reload is requested. Software picks one of two reload triggers. An immediate reload copies the words on the next clock. A blanking-synchronised reload waits for a vertical-blank strobe from the timing generator, so a whole group of settings changes between frames and never in the middle of one.

The same block owns four interrupt sources:

- a line-position strobe;
- a pixel FIFO underrun pulse;
- a bus transfer error pulse;
- its own reload-complete event.

Each source has a sticky status flag and an enable bit. Flags are cleared by writing ones to a clear register. A single interrupt line reports any flag that is both set and enabled.

All accesses go through a single write port. Addresses 0 to NUM_REGS-1 select the staging words. The next three addresses select, in order, the reload-request register, the interrupt-enable register and the interrupt-clear register.

Top module: `cfg_shadow_ctrl`

## Requirements
- R1: A write to a staging word never changes the working copy until a reload is performed.
- R2: Writing a 1 to bit 0 of the reload-request register (address NUM_REGS) arms an immediate reload. On the next clock edge every working word takes its staging value and the request bit returns to 0.
- R3: Writing a 1 to bit 1 of the reload-request register arms a blanking reload. That request waits, with the working copy unchanged, until a clock edge at which the vertical-blank strobe is high. At that edge the copy happens and the request bit returns to 0.
- R4: If both request bits are pending, the immediate reload wins. That one copy clears both bits and produces a single reload-complete event, so no second copy follows at blanking.
- R5: A reload sets status flag bit 3 (reload done) on the same clock edge that updates the working copy.
- R6: A pulse on the line strobe, the FIFO underrun input or the transfer error input sets status flag bit 0, 1 or 2 respectively. This happens whatever the enable bits hold.
- R7: Writing a value to the clear register (address NUM_REGS+2) clears exactly the flags whose bits are 1 in that value. All other flags are unchanged.
- R8: When an event and a clear for the same flag arrive on the same clock edge, the flag remains set.
- R9: The interrupt output is high exactly when some flag is set whose bit is also 1 in the enable register (address NUM_REGS+1, bits 0 to 3 matching the flag positions).
- R10: After reset, every working word holds RESET_VAL, all flags, enables and request bits are 0, and the interrupt output is low.
- R11: Writing to the reload-request register only sets bits. Writing a 0 to a pending request bit leaves that request pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | ADDR_W | Write address (staging words, then reload, enable, clear) |
| wr_data | input | DATA_W | Write data |
| vblank_stb | input | 1 | Vertical-blank strobe from the timing generator |
| line_stb | input | 1 | Line-position match strobe |
| fifo_urun | input | 1 | Pixel FIFO underrun pulse |
| xfer_err | input | 1 | Bus transfer error pulse |
| active_cfg | output | NUM_REGS*DATA_W | Working copy, word i at bits i*DATA_W upward |
| reload_pend | output | 2 | Pending reload requests (bit 0 immediate, bit 1 blanking) |
| irq_flags | output | 4 | Sticky status flags (line, underrun, error, reload) |
| irq | output | 1 | Combined enabled interrupt |

## Verification
Faults in the request state show up quickly. A request bit that fails to self-clear is visible on reload_pend one edge after the copy. It also produces a repeated reload-done flag that reappears after software clears it. A wrongly armed blanking request shows up as a working-copy change on an edge without the strobe.

Flag faults appear on irq_flags at the edge after the stimulus. This includes losing the event-over-clear priority or clearing the wrong bit. A broken enable mask becomes visible on irq in the same cycle the enable write lands.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
   // interrupt flag positions (shared by enable, status and clear)
   localparam int IRQ_N      = 4;
   localparam int IRQ_LINE   = 0;
   localparam int IRQ_FIFO   = 1;
   localparam int IRQ_XFER   = 2;
   localparam int IRQ_RELOAD = 3;

   // reload request bit positions
   localparam int RLD_N   = 2;
   localparam int RLD_IMM = 0;
   localparam int RLD_VBL = 1;

   // control registers located right after the staging words
   localparam int NUM_CTRL    = 3;
   localparam int OFS_RELOAD  = 0;
   localparam int OFS_IRQ_EN  = 1;
   localparam int OFS_IRQ_CLR = 2;

   typedef logic [IRQ_N-1:0] irq_vec_t;
   typedef logic [RLD_N-1:0] rld_vec_t;
endpackage

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 32,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_REGS-1:0]        wr_sel,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       copy,
   output logic [NUM_REGS*DATA_W-1:0] active_flat
);
   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
         logic [DATA_W-1:0] stage_q;
         logic [DATA_W-1:0] work_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= RESET_VAL;
            end else if (wr_sel[g]) begin
               stage_q <= wr_data;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               work_q <= RESET_VAL;
            end else if (copy) begin
               work_q <= stage_q;
            end
         end

         assign active_flat[g*DATA_W +: DATA_W] = work_q;
      end
   endgenerate
endmodule

// File: rtl/cfg_reload_seq.sv
module cfg_reload_seq
   import cfg_shadow_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_wr,
   input  rld_vec_t req_bits,
   input  logic     vblank_stb,
   output rld_vec_t pend,
   output logic     copy
);
   rld_vec_t pend_q;
   rld_vec_t drop;
   logic     imm_go;
   logic     vbl_go;

   assign imm_go = pend_q[RLD_IMM];
   assign vbl_go = pend_q[RLD_VBL] & vblank_stb & ~pend_q[RLD_IMM];
   assign copy   = imm_go | vbl_go;

   always_comb begin
      drop = '0;
      if (imm_go) begin
         drop = '1;                 // immediate copy satisfies both requests
      end else if (vbl_go) begin
         drop[RLD_VBL] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= (pend_q & ~drop) | (req_wr ? req_bits : rld_vec_t'('0));
      end
   end

   assign pend = pend_q;
endmodule

// File: rtl/cfg_irq_unit.sv
module cfg_irq_unit
   import cfg_shadow_pkg::*;
#(
   parameter bit IRQ_OUT_REG = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en_wr,
   input  logic     clr_wr,
   input  irq_vec_t wr_bits,
   input  irq_vec_t events,
   output irq_vec_t flags,
   output irq_vec_t enables,
   output logic     irq
);
   irq_vec_t flag_q;
   irq_vec_t en_q;
   irq_vec_t clr_mask;
   logic     irq_raw;

   assign clr_mask = clr_wr ? wr_bits : irq_vec_t'('0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         flag_q <= (flag_q & ~clr_mask) | events;   // event beats clear
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_wr) begin
         en_q <= wr_bits;
      end
   end

   assign irq_raw = |(flag_q & en_q);

   generate
      if (IRQ_OUT_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= irq_raw;
            end
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate

   assign flags   = flag_q;
   assign enables = en_q;
endmodule

// File: rtl/cfg_shadow_ctrl.sv
module cfg_shadow_ctrl
   import cfg_shadow_pkg::*;
#(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 32,
   parameter logic [DATA_W-1:0] RESET_VAL = '0,
   parameter bit IRQ_OUT_REG = 1'b0,
   localparam int ADDR_W = $clog2(NUM_REGS + NUM_CTRL)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       vblank_stb,
   input  logic                       line_stb,
   input  logic                       fifo_urun,
   input  logic                       xfer_err,
   output logic [NUM_REGS*DATA_W-1:0] active_cfg,
   output logic [1:0]                 reload_pend,
   output logic [3:0]                 irq_flags,
   output logic                       irq
);
   localparam int ADDR_RELOAD  = NUM_REGS + OFS_RELOAD;
   localparam int ADDR_IRQ_EN  = NUM_REGS + OFS_IRQ_EN;
   localparam int ADDR_IRQ_CLR = NUM_REGS + OFS_IRQ_CLR;

   generate
      if (NUM_REGS < 1) begin : g_bad_regs
         $error("cfg_shadow_ctrl: NUM_REGS must be at least 1");
      end
      if (DATA_W < IRQ_N) begin : g_bad_width
         $error("cfg_shadow_ctrl: DATA_W must hold the interrupt bits");
      end
   endgenerate

   logic [NUM_REGS-1:0] stage_sel;
   logic                sel_reload;
   logic                sel_en;
   logic                sel_clr;
   logic                copy;
   irq_vec_t            events;
   irq_vec_t            irq_en_q;
   rld_vec_t            pend;
   irq_vec_t            flags;

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
         assign stage_sel[g] = wr_en && (int'(wr_addr) == g);
      end
   endgenerate

   assign sel_reload = wr_en && (int'(wr_addr) == ADDR_RELOAD);
   assign sel_en     = wr_en && (int'(wr_addr) == ADDR_IRQ_EN);
   assign sel_clr    = wr_en && (int'(wr_addr) == ADDR_IRQ_CLR);

   cfg_shadow_bank #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .RESET_VAL(RESET_VAL)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_sel     (stage_sel),
      .wr_data    (wr_data),
      .copy       (copy),
      .active_flat(active_cfg)
   );

   cfg_reload_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_wr    (sel_reload),
      .req_bits  (wr_data[RLD_N-1:0]),
      .vblank_stb(vblank_stb),
      .pend      (pend),
      .copy      (copy)
   );

   always_comb begin
      events             = '0;
      events[IRQ_LINE]   = line_stb;
      events[IRQ_FIFO]   = fifo_urun;
      events[IRQ_XFER]   = xfer_err;
      events[IRQ_RELOAD] = copy;
   end

   cfg_irq_unit #(
      .IRQ_OUT_REG(IRQ_OUT_REG)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_wr  (sel_en),
      .clr_wr (sel_clr),
      .wr_bits(wr_data[IRQ_N-1:0]),
      .events (events),
      .flags  (flags),
      .enables(irq_en_q),
      .irq    (irq)
   );

   assign reload_pend = pend;
   assign irq_flags   = flags;
endmodule

// File: rtl/cfg_shadow_chk.sv
module cfg_shadow_chk #(
   parameter int NUM_REGS = 4,
   parameter int DATA_W   = 32,
   localparam int ADDR_W  = $clog2(NUM_REGS + 3)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [DATA_W-1:0]          wr_data,
   input logic                       vblank_stb,
   input logic                       line_stb,
   input logic [NUM_REGS*DATA_W-1:0] active_cfg,
   input logic [1:0]                 reload_pend,
   input logic [3:0]                 irq_flags
);
   logic rld_wr;
   assign rld_wr = wr_en && (int'(wr_addr) == NUM_REGS);

   // R1
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_pend == 2'b00) |=> $stable(active_cfg));

   // R2
   imm_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_pend[0] && !(rld_wr && wr_data[0])) |=> !reload_pend[0]);

   // R3
   vbl_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_pend == 2'b10 && !vblank_stb) |=> $stable(active_cfg));

   // R4
   imm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_pend[0] && !(rld_wr && wr_data[1])) |=> !reload_pend[1]);

   // R5
   done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload_pend[0] |=> irq_flags[3]);

   // R6
   line_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_stb |=> irq_flags[0]);
endmodule

bind cfg_shadow_ctrl cfg_shadow_chk #(
   .NUM_REGS(NUM_REGS),
   .DATA_W  (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .vblank_stb (vblank_stb),
   .line_stb   (line_stb),
   .active_cfg (active_cfg),
   .reload_pend(reload_pend),
   .irq_flags  (irq_flags)
);

// File: tb/cfg_shadow_ctrl_bench.sv
module cfg_shadow_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NREG  = 4;
   localparam int DW    = 32;
   localparam int AW    = 3;
   localparam int A_RLD = 4;
   localparam int A_EN  = 5;
   localparam int A_CLR = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [DW-1:0]   wr_data = '0;
   logic            vblank_stb = 1'b0;
   logic            line_stb = 1'b0;
   logic            fifo_urun = 1'b0;
   logic            xfer_err = 1'b0;
   logic [NREG*DW-1:0] active_cfg;
   logic [1:0]      reload_pend;
   logic [3:0]      irq_flags;
   logic            irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_shadow_ctrl u_cfg_shadow_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .vblank_stb(vblank_stb), .line_stb(line_stb),
      .fifo_urun(fifo_urun), .xfer_err(xfer_err), .active_cfg(active_cfg),
      .reload_pend(reload_pend), .irq_flags(irq_flags), .irq(irq)
   );

   typedef enum int {K_WORD, K_FLAGS, K_PEND, K_IRQ} kind_t;
   typedef struct {
      kind_t       kind;
      int          idx;
      logic [31:0] val;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;

   task automatic expect_item(kind_t k, int idx, logic [31:0] v, string r);
      exp_t e;
      e.kind = k; e.idx = idx; e.val = v; e.req = r;
      exp_q.push_back(e);
   endtask

   // one clock: drive inputs, take the edge, release; ev = {vbl,xfer,fifo,line}
   task automatic cyc(bit we, int a, logic [31:0] d, logic [3:0] ev);
      wr_en = we; wr_addr = AW'(a); wr_data = d;
      line_stb = ev[0]; fifo_urun = ev[1]; xfer_err = ev[2]; vblank_stb = ev[3];
      @(posedge clk);
      #1;
      wr_en = 1'b0; line_stb = 1'b0; fifo_urun = 1'b0; xfer_err = 1'b0;
      vblank_stb = 1'b0;
   endtask

   task automatic wr(int a, logic [31:0] d);
      cyc(1'b1, a, d, 4'b0000);
   endtask

   // monitor: compares pending expectations away from the active edge
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         exp_t e;
         logic [31:0] act;
         e = exp_q.pop_front();
         case (e.kind)
            K_WORD:  act = active_cfg[e.idx*DW +: DW];
            K_FLAGS: act = 32'(irq_flags);
            K_PEND:  act = 32'(reload_pend);
            default: act = 32'(irq);
         endcase
         n_checks++;
         if (act !== e.val) begin
            n_fail++;
            $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                     e.req, e.kind, e.idx, act, e.val);
         end
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10 reset state
      for (int i = 0; i < NREG; i++) expect_item(K_WORD, i, 32'h0, "R10");
      expect_item(K_FLAGS, 0, 32'h0, "R10");
      expect_item(K_PEND, 0, 32'h0, "R10");
      expect_item(K_IRQ, 0, 32'h0, "R10");
      cyc(1'b0, 0, 0, 4'b0000);

      // R1 staging writes leave working copy alone
      wr(0, 32'hA5A5_0001);
      wr(1, 32'hA5A5_0002);
      expect_item(K_WORD, 0, 32'h0, "R1");
      expect_item(K_WORD, 1, 32'h0, "R1");
      cyc(1'b0, 0, 0, 4'b0000);

      // R2 immediate reload, R5 done flag
      wr(A_RLD, 32'h1);
      expect_item(K_PEND, 0, 32'h1, "R2");
      cyc(1'b0, 0, 0, 4'b0000);
      expect_item(K_WORD, 0, 32'hA5A5_0001, "R2");
      expect_item(K_WORD, 1, 32'hA5A5_0002, "R2");
      expect_item(K_PEND, 0, 32'h0, "R2");
      expect_item(K_FLAGS, 0, 32'h8, "R5");
      expect_item(K_IRQ, 0, 32'h0, "R9");
      wr(A_CLR, 32'h8);
      expect_item(K_FLAGS, 0, 32'h0, "R7");

      // R3 blanking reload waits for the strobe
      wr(0, 32'hB0B0_0003);
      wr(A_RLD, 32'h2);
      expect_item(K_PEND, 0, 32'h2, "R3");
      repeat (3) cyc(1'b0, 0, 0, 4'b0000);
      expect_item(K_WORD, 0, 32'hA5A5_0001, "R3");
      expect_item(K_PEND, 0, 32'h2, "R3");
      cyc(1'b0, 0, 0, 4'b1000);
      expect_item(K_WORD, 0, 32'hB0B0_0003, "R3");
      expect_item(K_PEND, 0, 32'h0, "R3");
      expect_item(K_FLAGS, 0, 32'h8, "R5");

      // R11 set-only request register
      wr(A_CLR, 32'h8);
      wr(0, 32'hC0C0_0004);
      wr(A_RLD, 32'h2);
      wr(A_RLD, 32'h0);
      expect_item(K_PEND, 0, 32'h2, "R11");
      expect_item(K_WORD, 0, 32'hB0B0_0003, "R11");
      cyc(1'b0, 0, 0, 4'b1000);
      expect_item(K_WORD, 0, 32'hC0C0_0004, "R11");

      // R4 both requests: immediate wins, single copy
      wr(A_CLR, 32'h8);
      wr(0, 32'hD0D0_0005);
      wr(A_RLD, 32'h3);
      expect_item(K_PEND, 0, 32'h3, "R4");
      cyc(1'b0, 0, 0, 4'b0000);
      expect_item(K_WORD, 0, 32'hD0D0_0005, "R4");
      expect_item(K_PEND, 0, 32'h0, "R4");
      expect_item(K_FLAGS, 0, 32'h8, "R4");
      wr(A_CLR, 32'h8);
      wr(0, 32'hE0E0_0006);
      cyc(1'b0, 0, 0, 4'b1000);
      expect_item(K_FLAGS, 0, 32'h0, "R4");
      expect_item(K_WORD, 0, 32'hD0D0_0005, "R4");

      // R6 events set flags with all enables off
      cyc(1'b0, 0, 0, 4'b0111);
      expect_item(K_FLAGS, 0, 32'h7, "R6");
      expect_item(K_IRQ, 0, 32'h0, "R6");

      // R7 selective clear
      wr(A_CLR, 32'h2);
      expect_item(K_FLAGS, 0, 32'h5, "R7");

      // R9 enable masking
      wr(A_EN, 32'h4);
      expect_item(K_IRQ, 0, 32'h1, "R9");
      wr(A_EN, 32'h2);
      expect_item(K_IRQ, 0, 32'h0, "R9");
      wr(A_EN, 32'h1);
      expect_item(K_IRQ, 0, 32'h1, "R9");

      // R8 event beats clear on the same edge
      wr(A_CLR, 32'hF);
      expect_item(K_FLAGS, 0, 32'h0, "R7");
      expect_item(K_IRQ, 0, 32'h0, "R9");
      cyc(1'b1, A_CLR, 32'h2, 4'b0010);
      expect_item(K_FLAGS, 0, 32'h2, "R8");

      repeat (3) @(posedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule